// File: doc/BRIEF.md
# Two-Phase Link Training Sequencer

This block runs the training of a multi-lane serial link in two phases. First comes clock recovery: it commands training pattern 1, asks an external drive adjuster to apply new drive levels, waits a fixed settling time and then asks an external transport to fetch a six-byte status snapshot from the sink. It repeats this until every active lane reports clock lock, until a failing lane is already at its highest swing, or until the retry budget runs out. Second comes equalization: it commands pattern 3 if the sink can use it, otherwise pattern 2, and loops on status reads with drive updates in between until lanes report equalized, symbol-locked and inter-lane aligned.

Whatever the outcome, the block commands pattern 0 (off) and then pulses a done strobe with a pass or fail verdict. The drive arithmetic, the sideband transport and the pattern generators sit outside the block. They are reached through request/acknowledge handshakes.

Top module: `link_train_seq`

## Requirements
- R1: A start pulse while idle writes pattern 1 (pattern write strobe high for one cycle) and begins clock-recovery iterations, each made of a drive request, a wait, and a status request, in that order.
- R2: The wait begins at the cycle the drive acknowledge is taken, lasts CR_WAIT_US*CYC_PER_US cycles in clock recovery and EQ_WAIT_US*CYC_PER_US cycles in equalization, and then the status request is raised.
- R3: When the read-interval input sampled at start is nonzero, every wait becomes that value times 4000 microseconds.
- R4: Clock recovery passes when each active lane (index below the lane count sampled at start) has bit 0 (clock lock) set in its status nibble; lane i's nibble is status byte i/2, bits 4*(i%2) upward, with byte k at status bits 8k+7..8k. Inactive lanes are ignored.
- R5: If the lowest-numbered active lane failing clock lock had its max-swing flag set at the last drive acknowledge, the phase ends at once with fail; a max-swing flag on a later failing lane has no effect.
- R6: The clock-recovery try count restarts whenever the lane 0 swing captured at a drive acknowledge differs from the previous value (starting value 0); the phase fails once 5 consecutive tries pass with no such change.
- R7: Equalization writes pattern 3 when the sink capability input sampled at start is set, else pattern 2, and its first iteration issues no drive request; later iterations do.
- R8: Equalization passes only when status bit 16 (inter-lane alignment) is set and each active lane shows bit 0 (clock lock), bit 1 (equalized) and bit 2 (symbol lock).
- R9: Equalization fails at once if any active lane has lost clock lock, and fails after the sixth status read without success.
- R10: At the end of training pattern 0 is written, and one cycle later done pulses for one cycle with exactly one of pass and fail set; the verdict holds until the next start.
- R11: Drive and status requests hold until acknowledged, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a training run (taken while idle) |
| lane_cnt_i | input | LCW | Number of active lanes |
| tps3_cap_i | input | 1 | Sink accepts pattern 3 |
| rd_interval_i | input | 8 | Sink read-interval field, 0 selects fixed waits |
| pattern_o | output | 2 | Commanded training pattern |
| pat_we_o | output | 1 | One-cycle strobe when pattern_o is written |
| drive_req_o | output | 1 | Request to the drive adjuster |
| drive_ack_i | input | 1 | Drive adjuster done; swing and flags valid |
| lane0_swing_i | input | 2 | Swing level now set on lane 0 |
| max_swing_i | input | NUM_LANES | Per-lane max-swing flags now set |
| stat_req_o | output | 1 | Request a status snapshot |
| stat_vld_i | input | 1 | Snapshot valid |
| stat_i | input | 48 | Six status bytes, byte k at bits 8k+7..8k |
| done_o | output | 1 | One-cycle end-of-training pulse |
| pass_o | output | 1 | Training succeeded |
| fail_o | output | 1 | Training failed or aborted |

## Verification
A corrupted try count or swing reference shows up as a wrong number of status reads before done. That count is visible within one iteration, a few hundred cycles at a fast bench rate. A wrong phase or first-failing-lane decision appears as a wrong verdict, a wrong pattern value at the phase boundary, or a drive request issued on the first equalization pass. A timer fault moves the rise of the status request away from the expected cycle after each drive acknowledge, so it is exposed on the first iteration.

// File: rtl/link_train_pkg.sv
package link_train_pkg;
  localparam int STAT_W    = 48;
  localparam int BIT_CR    = 0;
  localparam int BIT_EQ    = 1;
  localparam int BIT_SYM   = 2;
  localparam int BIT_ALIGN = 16;
  localparam int MS_PER_RD = 4000;  // us per read-interval unit

  typedef enum logic [1:0] {
    PAT_OFF = 2'd0, PAT_1 = 2'd1, PAT_2 = 2'd2, PAT_3 = 2'd3
  } pat_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CR_DRV, ST_CR_WAIT, ST_CR_RD,
    ST_EQ_DRV, ST_EQ_WAIT, ST_EQ_RD, ST_FIN
  } lt_state_e;
endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [CW-1:0] load_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (go_i) begin
      cnt_q  <= load_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assign expire_o = busy_q && (cnt_q == CW'(1));

  p_load_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> load_i != '0);
  p_expire_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
endmodule

// File: rtl/lt_lane_eval.sv
module lt_lane_eval
  import link_train_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int LCW = $clog2(NUM_LANES + 1)
) (
  input  logic [STAT_W-1:0]    stat_i,
  input  logic [LCW-1:0]       lane_cnt_i,
  input  logic [NUM_LANES-1:0] max_swing_i,
  output logic                 cr_all_o,
  output logic                 eq_all_o,
  output logic                 abort_o
);
  logic [NUM_LANES-1:0] cr_ok, full_ok;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    localparam int BASE = (l / 2) * 8 + (l % 2) * 4;
    logic [3:0] nib;
    logic       act;
    assign nib        = stat_i[BASE +: 4];
    assign act        = LCW'(l) < lane_cnt_i;
    assign cr_ok[l]   = !act || nib[BIT_CR];
    assign full_ok[l] = !act || (nib[BIT_CR] && nib[BIT_EQ] && nib[BIT_SYM]);
  end

  // only the lowest failing lane decides abort
  always_comb begin
    logic found;
    found   = 1'b0;
    abort_o = 1'b0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (!found && !cr_ok[l]) begin
        found   = 1'b1;
        abort_o = max_swing_i[l];
      end
    end
  end

  assign cr_all_o = &cr_ok;
  assign eq_all_o = stat_i[BIT_ALIGN] && (&full_ok);
endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
  import link_train_pkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int CYC_PER_US   = 50,
  parameter int CR_WAIT_US   = 100,
  parameter int EQ_WAIT_US   = 400,
  parameter int MAX_CR_TRIES = 5,
  parameter int MAX_EQ_TRIES = 5,
  localparam int LCW   = $clog2(NUM_LANES + 1),
  localparam int TRY_W = $clog2(MAX_CR_TRIES + MAX_EQ_TRIES + 2),
  localparam int TW    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [LCW-1:0]       lane_cnt_i,
  input  logic                 tps3_cap_i,
  input  logic [7:0]           rd_interval_i,
  output logic [1:0]           pattern_o,
  output logic                 pat_we_o,
  output logic                 drive_req_o,
  input  logic                 drive_ack_i,
  input  logic [1:0]           lane0_swing_i,
  input  logic [NUM_LANES-1:0] max_swing_i,
  output logic                 stat_req_o,
  input  logic                 stat_vld_i,
  input  logic [STAT_W-1:0]    stat_i,
  output logic                 done_o,
  output logic                 pass_o,
  output logic                 fail_o
);
  lt_state_e            state_q;
  logic [LCW-1:0]       lanes_q;
  logic                 tps3_q, res_q;
  logic [7:0]           rdint_q;
  logic [1:0]           swing_q, swing_ref_q;
  logic [NUM_LANES-1:0] maxf_q;
  logic [TRY_W-1:0]     tries_q, t_cr, t_eq;
  logic                 cr_all, eq_all, abort_hit, expire, tmr_go, wait_eq;
  logic [TW-1:0]        wait_us, wait_cyc;

  lt_lane_eval #(.NUM_LANES(NUM_LANES)) u_eval (
    .stat_i     (stat_i),
    .lane_cnt_i (lanes_q),
    .max_swing_i(maxf_q),
    .cr_all_o   (cr_all),
    .eq_all_o   (eq_all),
    .abort_o    (abort_hit)
  );

  assign drive_req_o = (state_q == ST_CR_DRV) || (state_q == ST_EQ_DRV);
  assign stat_req_o  = (state_q == ST_CR_RD)  || (state_q == ST_EQ_RD);

  // timer starts on drive ack, or straight from a passing CR read
  assign tmr_go  = (drive_req_o && drive_ack_i) ||
                   (state_q == ST_CR_RD && stat_vld_i && cr_all);
  assign wait_eq = (state_q != ST_CR_DRV);
  assign wait_us = (rdint_q != 8'd0) ? TW'(rdint_q) * TW'(MS_PER_RD)
                 : (wait_eq ? TW'(EQ_WAIT_US) : TW'(CR_WAIT_US));
  assign wait_cyc = wait_us * TW'(CYC_PER_US);

  lt_wait_timer #(.CW(TW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (tmr_go),
    .load_i  (wait_cyc),
    .expire_o(expire)
  );

  assign t_cr = (swing_q != swing_ref_q) ? TRY_W'(1) : tries_q + 1'b1;
  assign t_eq = tries_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lanes_q     <= '0;
      tps3_q      <= 1'b0;
      rdint_q     <= '0;
      swing_q     <= '0;
      swing_ref_q <= '0;
      maxf_q      <= '0;
      tries_q     <= '0;
      res_q       <= 1'b0;
      pattern_o   <= PAT_OFF;
      pat_we_o    <= 1'b0;
      done_o      <= 1'b0;
      pass_o      <= 1'b0;
      fail_o      <= 1'b0;
    end else begin
      pat_we_o <= 1'b0;
      done_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          lanes_q     <= lane_cnt_i;
          tps3_q      <= tps3_cap_i;
          rdint_q     <= rd_interval_i;
          swing_q     <= '0;
          swing_ref_q <= '0;
          maxf_q      <= '0;
          tries_q     <= '0;
          pass_o      <= 1'b0;
          fail_o      <= 1'b0;
          pattern_o   <= PAT_1;
          pat_we_o    <= 1'b1;
          state_q     <= ST_CR_DRV;
        end
        ST_CR_DRV: if (drive_ack_i) begin
          swing_q <= lane0_swing_i;
          maxf_q  <= max_swing_i;
          state_q <= ST_CR_WAIT;
        end
        ST_CR_WAIT: if (expire) state_q <= ST_CR_RD;
        ST_CR_RD: if (stat_vld_i) begin
          if (cr_all) begin
            pattern_o <= tps3_q ? PAT_3 : PAT_2;
            pat_we_o  <= 1'b1;
            tries_q   <= '0;
            state_q   <= ST_EQ_WAIT;
          end else if (abort_hit || int'(t_cr) >= MAX_CR_TRIES) begin
            pattern_o <= PAT_OFF;
            pat_we_o  <= 1'b1;
            res_q     <= 1'b0;
            state_q   <= ST_FIN;
          end else begin
            swing_ref_q <= swing_q;
            tries_q     <= t_cr;
            state_q     <= ST_CR_DRV;
          end
        end
        ST_EQ_DRV: if (drive_ack_i) state_q <= ST_EQ_WAIT;
        ST_EQ_WAIT: if (expire) state_q <= ST_EQ_RD;
        ST_EQ_RD: if (stat_vld_i) begin
          if (eq_all || !cr_all || int'(t_eq) > MAX_EQ_TRIES) begin
            pattern_o <= PAT_OFF;
            pat_we_o  <= 1'b1;
            res_q     <= eq_all;
            state_q   <= ST_FIN;
          end else begin
            tries_q <= t_eq;
            state_q <= ST_EQ_DRV;
          end
        end
        ST_FIN: begin
          done_o  <= 1'b1;
          pass_o  <= res_q;
          fail_o  <= !res_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_req_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drive_req_o && stat_req_o));
  p_drv_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_req_o && !drive_ack_i |=> drive_req_o);
  p_stat_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_req_o && !stat_vld_i |=> stat_req_o);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_verdict_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o != fail_o) && pattern_o == PAT_OFF);
  p_off_then_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_we_o && pattern_o == PAT_OFF |=> done_o);
  p_eq_no_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_we_o && pattern_o[1] |-> !drive_req_o);
endmodule

// File: tb/link_train_seq_test.sv
`timescale 1ns/1ps
module link_train_seq_test;
  localparam int NL = 4;
  localparam int CR_N = 100;
  localparam int EQ_N = 400;

  typedef struct packed {
    logic       pass;
    logic [3:0] cr_rd;
    logic [3:0] eq_rd;
    logic [1:0] eq_pat;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic start = 0, tps3 = 0, drv_ack = 0, st_vld = 0;
  logic [2:0] lane_cnt = 3'd4;
  logic [7:0] rdint = 0;
  logic [1:0] sw = 0;
  logic [NL-1:0] maxs = 0;
  logic [47:0] stat = 0;
  logic [1:0] pat;
  logic pat_we, drv_req, st_req, done, pass, fail;

  always #10 clk = ~clk;

  link_train_seq #(.NUM_LANES(NL), .CYC_PER_US(1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lane_cnt_i(lane_cnt),
    .tps3_cap_i(tps3), .rd_interval_i(rdint), .pattern_o(pat), .pat_we_o(pat_we),
    .drive_req_o(drv_req), .drive_ack_i(drv_ack), .lane0_swing_i(sw),
    .max_swing_i(maxs), .stat_req_o(st_req), .stat_vld_i(st_vld), .stat_i(stat),
    .done_o(done), .pass_o(pass), .fail_o(fail)
  );

  int errors = 0, checks = 0, cyc = 0;
  int cr_rd_n, eq_rd_n, cr_drv_n, eq_drv_n, ack_cyc;
  logic [1:0] eq_pat_seen, last_pat;
  logic have_ack, done_seen;
  int cr_ok_after, eq_ok_after, eq_lost_at, swing_chg_at, eq_kind;
  logic [NL-1:0] max_mask;
  exp_t q[$];

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [47:0] make_stat(input logic cr_ph, input int idx);
    logic [3:0] ln [4];
    logic al;
    al = 1'b0;
    if (cr_ph) begin
      if (cr_ok_after != 0 && idx >= cr_ok_after) ln = '{4'h1, 4'h1, 4'h1, 4'h1};
      else ln = '{4'h1, 4'h0, 4'h0, 4'h1};
    end else if (eq_lost_at == idx) begin
      ln = '{4'h7, 4'h7, 4'h7, 4'h6}; al = 1'b1;
    end else if (eq_ok_after != 0 && idx >= eq_ok_after) begin
      ln = '{4'h7, 4'h7, 4'h7, 4'h7}; al = 1'b1;
    end else if (eq_kind == 0) begin
      ln = '{4'h5, 4'h5, 4'h5, 4'h5}; al = 1'b1;
    end else begin
      ln = '{4'h7, 4'h7, 4'h7, 4'h7}; al = 1'b0;
    end
    return {24'h0, 7'h0, al, ln[3], ln[2], ln[1], ln[0]};
  endfunction

  initial forever @(posedge clk) cyc++;

  // responders and monitor
  initial forever begin
    @(negedge clk);
    if (drv_ack) drv_ack = 0;
    else if (drv_req) begin
      if (pat == 2'd1) begin
        cr_drv_n++;
        sw = (swing_chg_at != 0 && cr_drv_n >= swing_chg_at) ? 2'd1 : 2'd0;
      end else eq_drv_n++;
      maxs = max_mask;
      drv_ack = 1; ack_cyc = cyc; have_ack = 1;
    end
    if (st_vld) st_vld = 0;
    else if (st_req) begin
      if (have_ack) begin
        int expw;
        expw = (rdint != 0) ? int'(rdint) * 4000 : ((pat == 2'd1) ? CR_N : EQ_N);
        chk(cyc - ack_cyc == expw + 1, (rdint != 0) ? "R3 wait" : "R2 wait",
            cyc - ack_cyc, expw + 1);
        have_ack = 0;
      end
      if (pat == 2'd1) begin cr_rd_n++; stat = make_stat(1, cr_rd_n); end
      else begin eq_rd_n++; stat = make_stat(0, eq_rd_n); end
      st_vld = 1;
    end
    if (pat_we) begin
      last_pat = pat;
      if (pat >= 2'd2) begin
        eq_pat_seen = pat;
        chk(!drv_req, "R7 no drive at EQ entry", int'(drv_req), 0);
      end
    end
    chk(!(drv_req && st_req), "R11 req overlap", int'(drv_req && st_req), 0);
    if (done) begin
      exp_t e;
      done_seen = 1;
      if (q.size() == 0) chk(0, "R10 unexpected done", 1, 0);
      else begin
        e = q.pop_front();
        chk(pass == e.pass, "R10 pass", int'(pass), int'(e.pass));
        chk(fail == !e.pass, "R10 fail", int'(fail), int'(!e.pass));
        chk(last_pat == 2'd0 && pat == 2'd0, "R10 pattern off", int'(pat), 0);
        chk(cr_rd_n == int'(e.cr_rd), "R6 CR reads", cr_rd_n, int'(e.cr_rd));
        chk(cr_drv_n == int'(e.cr_rd), "R1 CR drives", cr_drv_n, int'(e.cr_rd));
        chk(eq_rd_n == int'(e.eq_rd), "R9 EQ reads", eq_rd_n, int'(e.eq_rd));
        chk(eq_drv_n == ((e.eq_rd == 0) ? 0 : int'(e.eq_rd) - 1), "R7 EQ drives",
            eq_drv_n, (e.eq_rd == 0) ? 0 : int'(e.eq_rd) - 1);
        if (e.eq_rd != 0)
          chk(eq_pat_seen == e.eq_pat, "R7 EQ pattern", int'(eq_pat_seen), int'(e.eq_pat));
      end
    end
  end

  task automatic run(input int cr_ok, input int eq_ok, input int lost, input int swc,
                     input int kind, input logic [NL-1:0] mm, input logic t3,
                     input logic [2:0] lc, input logic [7:0] ri, input exp_t e);
    int t;
    @(negedge clk);
    cr_ok_after = cr_ok; eq_ok_after = eq_ok; eq_lost_at = lost;
    swing_chg_at = swc; eq_kind = kind; max_mask = mm;
    tps3 = t3; lane_cnt = lc; rdint = ri;
    cr_rd_n = 0; eq_rd_n = 0; cr_drv_n = 0; eq_drv_n = 0;
    eq_pat_seen = 0; have_ack = 0; done_seen = 0;
    q.push_back(e);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(pat == 2'd1 && last_pat == 2'd1, "R1 pattern 1 at start", int'(pat), 1);
    t = 0;
    while (!done_seen && t < 20000) begin @(negedge clk); t++; end
    if (!done_seen) begin chk(0, "watchdog", t, 20000); q.delete(); end
    @(negedge clk);
    chk(!done && (pass != fail), "R10 single done pulse", int'(done), 0);
  endtask

  initial begin
    last_pat = 0; cr_ok_after = 0; eq_ok_after = 0; eq_lost_at = 0;
    swing_chg_at = 0; eq_kind = 0; max_mask = 0; have_ack = 0; done_seen = 0;
    cr_rd_n = 0; eq_rd_n = 0; cr_drv_n = 0; eq_drv_n = 0; ack_cyc = 0; eq_pat_seen = 0;
    repeat (3) @(negedge clk);
    chk(pat == 0 && !pat_we && !drv_req && !st_req && !done && !pass && !fail,
        "R10 reset state", int'(pat), 0);
    rst_n = 1;
    @(negedge clk);
    // R4/R8 clean pass, pattern 3
    run(1, 1, 0, 0, 0, 4'b0, 1, 3'd4, 8'd0, '{1'b1, 4'd1, 4'd1, 2'd3});
    // R7 pattern 2, multi-iteration
    run(3, 2, 0, 0, 0, 4'b0, 0, 3'd4, 8'd0, '{1'b1, 4'd3, 4'd2, 2'd2});
    // R6 five tries, no swing change
    run(0, 0, 0, 0, 0, 4'b0, 1, 3'd4, 8'd0, '{1'b0, 4'd5, 4'd0, 2'd0});
    // R6 swing change on third drive restarts count
    run(0, 0, 0, 3, 0, 4'b0, 1, 3'd4, 8'd0, '{1'b0, 4'd7, 4'd0, 2'd0});
    // R5 abort: first failing lane 1 at max swing
    run(0, 0, 0, 0, 0, 4'b0010, 1, 3'd4, 8'd0, '{1'b0, 4'd1, 4'd0, 2'd0});
    // R5 max swing on later failing lane 2 only: no abort
    run(0, 0, 0, 0, 0, 4'b0100, 1, 3'd4, 8'd0, '{1'b0, 4'd5, 4'd0, 2'd0});
    // R9 EQ never equalizes: six reads
    run(1, 0, 0, 0, 0, 4'b0, 1, 3'd4, 8'd0, '{1'b0, 4'd1, 4'd6, 2'd3});
    // R9 clock lock lost on second EQ read
    run(1, 0, 2, 0, 0, 4'b0, 0, 3'd4, 8'd0, '{1'b0, 4'd1, 4'd2, 2'd2});
    // R8 lanes good but alignment missing
    run(2, 0, 0, 0, 1, 4'b0, 1, 3'd4, 8'd0, '{1'b0, 4'd2, 4'd6, 2'd3});
    // R4 single active lane ignores failing lanes 1 and 2
    run(0, 1, 0, 0, 0, 4'b0, 1, 3'd1, 8'd0, '{1'b1, 4'd1, 4'd1, 2'd3});
    // R3 read interval 1 -> 4000 us waits
    run(1, 2, 0, 0, 0, 4'b0, 0, 3'd4, 8'd1, '{1'b1, 4'd1, 4'd2, 2'd2});
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule